// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block is the trigger engine of a logic analyzer. Every clock it takes one sample of a 32-channel input bus and checks it against the condition set of the level it is on. One to four levels are walked in order. When the last active level is satisfied, the block raises a sticky triggered flag and, a fixed number of clocks later, drives a one-cycle pulse of selectable polarity on its trigger output.

Each channel of a level carries a condition code. The code matches a steady state (high or low), a transition (rising, falling or either) against the previous sample, or nothing at all. A level whose condition set holds any transition code is qualified by an occurrence count. A level made only of steady states is qualified by how long the match lasts, with either a greater-than or a less-than limit. Any level may also carry a timeout, and on expiry the timeout either sends the sequence back to the first level or forces the trigger.

Software loads the settings through a one-word write port and starts a capture with a single-cycle `arm` pulse.

Top module: `trig_sequencer`

## Requirements
- R1: After reset `trig_out` is 0, `triggered` is 0 and `cur_level` is 0, and no sample is evaluated until `arm` has been pulsed. All conditions reset to don't-care, all counts and limits to 0, timeouts off, one level, positive polarity.
- R2: A write with `cfg_addr[7]`=0 sets the 3-bit code `cfg_wdata[2:0]` for level `cfg_addr[6:5]` and channel `cfg_addr[4:0]`. The codes are 0 don't-care, 1 high, 2 low, 3 rising, 4 falling and 5 either edge. Steady-state codes compare the current sample only.
- R3: Transition codes compare the current sample with the previous one. The first sample after `arm` never matches a transition code.
- R4: A satisfied level advances `cur_level` by exactly one at that clock edge, and the next sample is evaluated against the new level.
- R5: A level with any transition code takes its count N from `cfg_wdata[9:0]` at address 0x80+level. It is satisfied on the (N+1)-th matching sample, so N=0 means the first match satisfies it.
- R6: A level with no transition code takes its duration settings from address 0x84+level, with the limit L in `cfg_wdata[9:0]` and the mode in bit 10. With bit 10 at 0 (greater-than), the level is satisfied on the sample at which the match has lasted L+1 consecutive samples.
- R7: With bit 10 at 1 (less-than), the level is satisfied on the first non-matching sample that ends a run of 1 to L-1 matching samples. Longer runs are discarded.
- R8: The timeout settings sit at address 0x88+level: the limit T in `cfg_wdata[23:0]`, enable in bit 24 and action in bit 25. With action 0, the T-th sample spent unsatisfied in the level returns the sequence to level 0.
- R9: With action 1, that same sample fires the trigger instead.
- R10: The trigger sample's clock edge sets `triggered`. After 32 further edges, `trig_out` changes from its idle value for exactly one cycle. The idle value is 0, or 1 when bit 2 of the global word at address 0x8C is set.
- R11: Once `triggered` is set it stays set and `cur_level` holds, whatever the samples, until the next `arm`, which clears it and returns to level 0.
- R12: The occurrence, duration and timeout counters all clear whenever a new level is entered.
- R13: The number of levels is `cfg_wdata[1:0]`+1 from address 0x8C, and the trigger fires only when the last of them is satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Single-cycle start: clear counters, flag and level |
| samp | input | 32 | Sampled channel bus, one sample per clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| trig_out | output | 1 | Delayed trigger pulse, polarity selectable |
| triggered | output | 1 | Sticky flag, set when the trigger fires |
| cur_level | output | 2 | Level currently being evaluated |

## Verification
The assertions take for granted that `arm` is a single-cycle pulse and that the polarity bit is not rewritten while an output pulse is in flight. They also assume that two triggers never come closer than two clocks apart, which holds because the sequencer stops after firing and needs a re-arm. The pulse-delay check counts from the edge that set `triggered`, so it assumes no re-arm falls between a trigger and its pulse. The stimulus keeps to all of this: configuration is written only between captures, every arm lasts one clock, and the delay tests start from reset so that no earlier pulse is still pending.

// File: rtl/trg_pkg.sv
// Shared definitions for the trigger sequencer: channel condition codes
// and configuration field selectors. Assumes 3-bit condition codes.
package trg_pkg;

    typedef enum logic [2:0] {
        COND_ANY  = 3'd0,
        COND_HIGH = 3'd1,
        COND_LOW  = 3'd2,
        COND_RISE = 3'd3,
        COND_FALL = 3'd4,
        COND_EDGE = 3'd5
    } cond_e;

    localparam logic [1:0] FLD_COUNT   = 2'd0;
    localparam logic [1:0] FLD_DUR     = 2'd1;
    localparam logic [1:0] FLD_TIMEOUT = 2'd2;
    localparam logic [1:0] FLD_GLOBAL  = 2'd3;

    // True when a code compares against the previous sample.
    function automatic logic is_transition(input logic [2:0] code);
        return (code == COND_RISE) || (code == COND_FALL) || (code == COND_EDGE);
    endfunction

endpackage

// File: rtl/trg_cfg_regs.sv
// Configuration storage for all levels. Decodes a one-word write port into
// per-channel condition codes, per-level qualifiers and global settings.
// Assumes LW + CHW + 1 <= AW and TW + 2 <= DW.
module trg_cfg_regs #(
    parameter int NCH  = 32,
    parameter int NLVL = 4,
    parameter int CW   = 10,
    parameter int TW   = 24,
    parameter int AW   = 8,
    parameter int DW   = 32,
    localparam int LW  = $clog2(NLVL),
    localparam int CHW = $clog2(NCH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [DW-1:0]                  wdata,
    output logic [NLVL-1:0][NCH-1:0][2:0]  cond,
    output logic [NLVL-1:0][CW-1:0]        occ_lim,
    output logic [NLVL-1:0]                dur_lt,
    output logic [NLVL-1:0][CW-1:0]        dur_lim,
    output logic [NLVL-1:0]                to_en,
    output logic [NLVL-1:0]                to_act,
    output logic [NLVL-1:0][TW-1:0]        to_lim,
    output logic [LW-1:0]                  last_lvl,
    output logic                           pol_neg
);
    import trg_pkg::*;

    logic          is_param;
    logic [LW-1:0] a_lvl_c;
    logic [LW-1:0] a_lvl_p;
    logic [CHW-1:0] a_ch;
    logic [1:0]    a_fld;
    logic [LW-1:0] new_last;

    // Split the address into its condition and parameter views.
    always_comb begin
        is_param = addr[AW-1];
        a_ch     = addr[CHW-1:0];
        a_lvl_c  = addr[CHW+LW-1:CHW];
        a_lvl_p  = addr[LW-1:0];
        a_fld    = addr[LW+1:LW];
        new_last = (int'(wdata[LW-1:0]) > NLVL-1) ? LW'(NLVL-1) : wdata[LW-1:0];
    end

    // Global settings: level count and output polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lvl <= '0;
            pol_neg  <= 1'b0;
        end else if (we && is_param && a_fld == FLD_GLOBAL) begin
            last_lvl <= new_last;
            pol_neg  <= wdata[2];
        end
    end

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        // Per-level qualifier words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_lim[l] <= '0;
                dur_lt[l]  <= 1'b0;
                dur_lim[l] <= '0;
                to_en[l]   <= 1'b0;
                to_act[l]  <= 1'b0;
                to_lim[l]  <= '0;
            end else if (we && is_param && int'(a_lvl_p) == l) begin
                case (a_fld)
                    FLD_COUNT: occ_lim[l] <= wdata[CW-1:0];
                    FLD_DUR: begin
                        dur_lim[l] <= wdata[CW-1:0];
                        dur_lt[l]  <= wdata[CW];
                    end
                    FLD_TIMEOUT: begin
                        to_lim[l] <= wdata[TW-1:0];
                        to_en[l]  <= wdata[TW];
                        to_act[l] <= wdata[TW+1];
                    end
                    default: ;
                endcase
            end
        end

        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // Per-channel condition code of this level.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cond[l][c] <= COND_ANY;
                else if (we && !is_param && int'(a_lvl_c) == l && int'(a_ch) == c)
                    cond[l][c] <= wdata[2:0];
            end
        end
    end

endmodule

// File: rtl/trg_match.sv
// Combinational pattern matcher for one level's condition set. Reports
// whether all channels match and whether any channel uses a transition code.
// Transition codes never match while prv_ok is low.
module trg_match #(
    parameter int NCH = 32
) (
    input  logic [NCH-1:0][2:0] cond,
    input  logic [NCH-1:0]      cur,
    input  logic [NCH-1:0]      prv,
    input  logic                prv_ok,
    output logic                hit,
    output logic                has_edge
);
    import trg_pkg::*;

    logic [NCH-1:0] ch_ok;
    logic [NCH-1:0] ch_edge;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Evaluate one channel against its code.
        always_comb begin
            ch_edge[c] = is_transition(cond[c]);
            case (cond[c])
                COND_HIGH: ch_ok[c] = cur[c];
                COND_LOW:  ch_ok[c] = !cur[c];
                COND_RISE: ch_ok[c] = prv_ok && !prv[c] && cur[c];
                COND_FALL: ch_ok[c] = prv_ok && prv[c] && !cur[c];
                COND_EDGE: ch_ok[c] = prv_ok && (prv[c] != cur[c]);
                default:   ch_ok[c] = 1'b1;
            endcase
        end
    end

    // Reduce channel results into the level verdict.
    always_comb begin
        hit      = &ch_ok;
        has_edge = |ch_edge;
    end

endmodule

// File: rtl/trg_qual.sv
// Qualifier for the active level: occurrence counter for transition
// patterns, run-length filter for steady patterns, and the level timeout.
// All counters clear on clr or whenever the level is left.
module trg_qual #(
    parameter int CW = 10,
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          hit,
    input  logic          has_edge,
    input  logic [CW-1:0] occ_lim,
    input  logic          dur_lt,
    input  logic [CW-1:0] dur_lim,
    input  logic          to_en,
    input  logic [TW-1:0] to_lim,
    output logic          sat,
    output logic          expire
);
    localparam logic [CW-1:0] RUN_MAX = '1;
    localparam logic [TW-1:0] TMR_MAX = '1;

    logic [CW-1:0] occ_q;
    logic [CW-1:0] run_q;
    logic [TW-1:0] tmr_q;
    logic          sat_cnt, sat_gt, sat_lt;

    // Decide satisfaction and expiry for this sample.
    always_comb begin
        sat_cnt = has_edge && hit && (occ_q == occ_lim);
        sat_gt  = !has_edge && !dur_lt && hit && (run_q >= dur_lim);
        sat_lt  = !has_edge && dur_lt && !hit && (run_q != '0) && (run_q < dur_lim);
        sat     = en && (sat_cnt || sat_gt || sat_lt);
        expire  = en && !sat && to_en && (({1'b0, tmr_q} + 1'b1) >= {1'b0, to_lim});
    end

    // Advance or clear the three counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || sat || expire) begin
            occ_q <= '0;
            run_q <= '0;
            tmr_q <= '0;
        end else if (en) begin
            if (has_edge && hit)
                occ_q <= occ_q + 1'b1;
            if (!hit)
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
            if (tmr_q != TMR_MAX)
                tmr_q <= tmr_q + 1'b1;
        end
    end

endmodule

// File: rtl/trg_outdly.sv
// Fixed-latency delay line for the trigger event. A pulse on fire appears
// on dly_out after DLY clock edges. DLY = 0 gives a combinational path.
module trg_outdly #(
    parameter int DLY = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic dly_out
);
    if (DLY == 0) begin : g_none
        assign dly_out = fire;
    end else begin : g_line
        logic [DLY-1:0] sr_q;

        // Shift the event toward the output one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sr_q <= '0;
            else
                sr_q <= {sr_q[DLY-2 >= 0 ? DLY-2 : 0:0], fire} & {DLY{1'b1}};
        end
        assign dly_out = sr_q[DLY-1];
    end

endmodule

// File: rtl/trig_sequencer.sv
// Top of the multi-level trigger sequencer. Evaluates one sample per clock
// against the current level, steps through up to NLVL levels and fires a
// delayed, polarity-selectable trigger pulse. Assumes arm is one cycle wide.
module trig_sequencer #(
    parameter int NCH     = 32,
    parameter int NLVL    = 4,
    parameter int CW      = 10,
    parameter int TW      = 24,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int OUT_DLY = 33,
    localparam int LW     = $clog2(NLVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic [NCH-1:0] samp,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic           trig_out,
    output logic           triggered,
    output logic [LW-1:0]  cur_level
);
    logic [NLVL-1:0][NCH-1:0][2:0] cond;
    logic [NLVL-1:0][CW-1:0]       occ_lim, dur_lim;
    logic [NLVL-1:0][TW-1:0]       to_lim;
    logic [NLVL-1:0]               dur_lt, to_en, to_act;
    logic [LW-1:0]                 last_lvl;
    logic                          pol_neg;

    logic           active_q, trig_q, prev_ok_q;
    logic [LW-1:0]  lvl_q;
    logic [NCH-1:0] prev_q;
    logic           eval, hit, has_edge, sat, expire, at_last, fire, dly_out;

    trg_cfg_regs #(.NCH(NCH), .NLVL(NLVL), .CW(CW), .TW(TW), .AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cond(cond), .occ_lim(occ_lim), .dur_lt(dur_lt), .dur_lim(dur_lim),
        .to_en(to_en), .to_act(to_act), .to_lim(to_lim),
        .last_lvl(last_lvl), .pol_neg(pol_neg)
    );

    trg_match #(.NCH(NCH)) u_match (
        .cond(cond[lvl_q]), .cur(samp), .prv(prev_q), .prv_ok(prev_ok_q),
        .hit(hit), .has_edge(has_edge)
    );

    trg_qual #(.CW(CW), .TW(TW)) u_qual (
        .clk(clk), .rst_n(rst_n), .clr(arm), .en(eval), .hit(hit), .has_edge(has_edge),
        .occ_lim(occ_lim[lvl_q]), .dur_lt(dur_lt[lvl_q]), .dur_lim(dur_lim[lvl_q]),
        .to_en(to_en[lvl_q]), .to_lim(to_lim[lvl_q]), .sat(sat), .expire(expire)
    );

    trg_outdly #(.DLY(OUT_DLY)) u_dly (
        .clk(clk), .rst_n(rst_n), .fire(fire), .dly_out(dly_out)
    );

    // Decide whether this sample is evaluated and whether it fires.
    always_comb begin
        eval    = active_q && !arm;
        at_last = (lvl_q >= last_lvl);
        fire    = eval && ((sat && at_last) || (expire && to_act[lvl_q]));
    end

    // Level stepping, sticky flag and previous-sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            trig_q    <= 1'b0;
            lvl_q     <= '0;
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else if (arm) begin
            active_q  <= 1'b1;
            trig_q    <= 1'b0;
            lvl_q     <= '0;
            prev_ok_q <= 1'b0;
        end else if (active_q) begin
            prev_q    <= samp;
            prev_ok_q <= 1'b1;
            if (fire) begin
                trig_q   <= 1'b1;
                active_q <= 1'b0;
            end else if (sat) begin
                lvl_q <= lvl_q + 1'b1;
            end else if (expire) begin
                lvl_q <= '0;
            end
        end
    end

    assign trig_out  = dly_out ^ pol_neg;
    assign triggered = trig_q;
    assign cur_level = lvl_q;

endmodule

// File: rtl/trg_checker.sv
// Protocol checks for trig_sequencer, attached by bind. Assumes arm is a
// single-cycle pulse and polarity is not rewritten during a pulse.
module trg_checker #(
    parameter int OUT_DLY = 33,
    parameter int LW      = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          cfg_we,
    input logic          trig_out,
    input logic          triggered,
    input logic [LW-1:0] cur_level,
    input logic          pol_neg
);
    localparam int CNTW = $clog2(OUT_DLY + 1) + 1;
    localparam logic [CNTW-1:0] CNT_MAX = '1;

    logic [CNTW-1:0] since_q;

    // Count clocks since the sticky flag was set.
    always_ff @(posedge clk) begin
        if (!rst_n || !triggered)
            since_q <= '0;
        else if (since_q != CNT_MAX)
            since_q <= since_q + 1'b1;
    end

    // R10: the pulse appears when the flag is OUT_DLY-1 clocks old.
    a_r10_pulse_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && int'(since_q) == OUT_DLY - 1) |-> (trig_out != pol_neg));

    // R10: the pulse is one cycle wide.
    a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_out != pol_neg) && !cfg_we) |=> (trig_out == pol_neg));

    // R11: the flag is sticky until re-armed.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);

    // R4: the level only steps up by one or returns to zero.
    a_r4_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_level) |-> (cur_level == '0 || cur_level == $past(cur_level) + 1'b1));

    // R11: the level is frozen while triggered.
    a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> $stable(cur_level));

endmodule

bind trig_sequencer trg_checker #(.OUT_DLY(OUT_DLY), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_we(cfg_we), .trig_out(trig_out),
    .triggered(triggered), .cur_level(cur_level), .pol_neg(pol_neg)
);

// File: tb/test_trig_sequencer.sv
// Self-checking bench for trig_sequencer.
module test_trig_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [31:0] samp = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trig_out, triggered;
    logic [1:0]  cur_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    trig_sequencer i_trig_sequencer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .samp(samp), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig_out(trig_out),
        .triggered(triggered), .cur_level(cur_level)
    );

    always #5 clk = ~clk;

    // Table: {code[2:0], first, second, exp_after_first, exp_after_second}
    localparam logic [6:0] VEC [12] = '{
        {3'd1, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd1, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd4, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd5, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'd0, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] d);
        samp = d;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_arm();
        samp = '0; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic do_reset();
        samp = '0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] a_cond(input int lvl, input int ch);
        return 8'(lvl * 32 + ch);
    endfunction

    function automatic logic [7:0] a_par(input int fld, input int lvl);
        return 8'(128 + fld * 4 + lvl);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state and no evaluation before arm.
        chk("R1 trig_out", 32'(trig_out), 0);
        chk("R1 triggered", 32'(triggered), 0);
        chk("R1 level", 32'(cur_level), 0);
        repeat (3) cyc(32'h0);
        chk("R1 unarmed", 32'(triggered), 0);

        // R2, R3: single-level condition table on channel 0.
        for (int i = 0; i < 12; i++) begin
            wr(a_cond(0, 0), 32'(VEC[i][6:4]));
            do_arm();
            cyc({31'b0, VEC[i][3]});
            chk($sformatf("R2/R3 vec%0d first", i), 32'(triggered), 32'(VEC[i][1]));
            cyc({31'b0, VEC[i][2]});
            chk($sformatf("R2/R3 vec%0d second", i), 32'(triggered), 32'(VEC[i][1] | VEC[i][0]));
        end

        // R4, R13: four levels, channel l high at level l.
        do_reset();
        for (int l = 0; l < 4; l++) wr(a_cond(l, l), 1);
        wr(a_par(3, 0), 3);
        do_arm();
        cyc(32'hF);
        chk("R4 one step", 32'(cur_level), 1);
        chk("R13 not yet", 32'(triggered), 0);
        cyc(32'h2);
        chk("R4 level2", 32'(cur_level), 2);
        cyc(32'h4);
        chk("R4 level3", 32'(cur_level), 3);
        chk("R13 not at 3", 32'(triggered), 0);
        cyc(32'h8);
        chk("R13 last fires", 32'(triggered), 1);

        // R5: rising edge counted, count 2 -> third rise.
        do_reset();
        wr(a_cond(0, 0), 3);
        wr(a_par(0, 0), 2);
        do_arm();
        cyc(0); cyc(1); cyc(0); cyc(1);
        chk("R5 two rises", 32'(triggered), 0);
        cyc(0); cyc(1);
        chk("R5 third rise", 32'(triggered), 1);

        // R6: greater-than 3 needs four consecutive highs.
        do_reset();
        wr(a_cond(0, 0), 1);
        wr(a_par(1, 0), 3);
        do_arm();
        cyc(1); cyc(1); cyc(0);
        cyc(1); cyc(1); cyc(1);
        chk("R6 three highs", 32'(triggered), 0);
        cyc(1);
        chk("R6 fourth high", 32'(triggered), 1);

        // R7: less-than 3 accepts a run of two, rejects a run of three.
        do_reset();
        wr(a_cond(0, 0), 1);
        wr(a_par(1, 0), (1 << 10) | 3);
        do_arm();
        cyc(0);
        chk("R7 no run", 32'(triggered), 0);
        cyc(1); cyc(1); cyc(1); cyc(0);
        chk("R7 run of three", 32'(triggered), 0);
        cyc(1); cyc(1); cyc(0);
        chk("R7 run of two", 32'(triggered), 1);

        // R8: timeout 4 at level 1 restarts the sequence.
        do_reset();
        wr(a_cond(0, 0), 1);
        wr(a_cond(1, 1), 1);
        wr(a_par(2, 1), (1 << 24) | 4);
        wr(a_par(3, 0), 1);
        do_arm();
        cyc(1);
        chk("R8 enter level1", 32'(cur_level), 1);
        cyc(0); cyc(0); cyc(0);
        chk("R8 before expiry", 32'(cur_level), 1);
        cyc(0);
        chk("R8 restart", 32'(cur_level), 0);
        cyc(2);
        chk("R8 level0 again", 32'(triggered), 0);
        cyc(1); cyc(2);
        chk("R8 fires after restart", 32'(triggered), 1);

        // R9: timeout 2 at level 1 forces the trigger.
        do_reset();
        wr(a_cond(0, 0), 1);
        wr(a_cond(1, 1), 1);
        wr(a_par(2, 1), (3 << 24) | 2);
        wr(a_par(3, 0), 1);
        do_arm();
        cyc(1); cyc(0);
        chk("R9 before expiry", 32'(triggered), 0);
        cyc(0);
        chk("R9 forced trigger", 32'(triggered), 1);

        // R12: occurrence count does not carry into the next level.
        do_reset();
        wr(a_cond(0, 0), 3);
        wr(a_cond(1, 0), 3);
        wr(a_par(0, 0), 1);
        wr(a_par(0, 1), 1);
        wr(a_par(3, 0), 1);
        do_arm();
        cyc(0); cyc(1); cyc(0); cyc(1);
        chk("R12 reach level1", 32'(cur_level), 1);
        cyc(0); cyc(1);
        chk("R12 count cleared", 32'(triggered), 0);
        cyc(0); cyc(1);
        chk("R12 second rise", 32'(triggered), 1);

        // R11: flag and level hold until re-armed.
        cyc(0); cyc(1); cyc(0);
        chk("R11 flag held", 32'(triggered), 1);
        chk("R11 level held", 32'(cur_level), 1);
        do_arm();
        chk("R11 arm clears", 32'(triggered), 0);
        chk("R11 arm level0", 32'(cur_level), 0);

        // R10: positive pulse 32 edges after the flag.
        do_reset();
        do_arm();
        cyc(0);
        chk("R10 flag set", 32'(triggered), 1);
        for (int k = 1; k <= 33; k++) begin
            @(negedge clk);
            chk($sformatf("R10 pos k%0d", k), 32'(trig_out), (k == 32) ? 1 : 0);
        end

        // R10: negative polarity.
        wr(a_par(3, 0), 4);
        chk("R10 idle high", 32'(trig_out), 1);
        do_arm();
        cyc(0);
        for (int k = 1; k <= 33; k++) begin
            @(negedge clk);
            chk($sformatf("R10 neg k%0d", k), 32'(trig_out), (k == 32) ? 0 : 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule